// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the arbitration core of an eight-input interrupt controller. It captures eight request lines into a request register, either on rising edges or by following the line level. It blocks masked lines and weighs the survivors against the in-service register. When a request outranks everything already in service, it raises a single interrupt line toward the processor.

When the processor acknowledges, the winning line moves from the request register into the in-service register. The block then presents a vector made of a programmable base, which is a multiple of eight, with the line number in the low three bits.

In-service bits are retired in one of three ways:
- a non-specific end-of-interrupt command, which retires the highest-ranked in-service bit;
- a specific end-of-interrupt command, which names the bit to retire;
- automatic retirement at acknowledge time.

Priority is either fixed, with line 0 first, or rotating. In rotating mode the line just retired becomes the lowest. All configuration and commands come from a separate command decoder as plain levels and single-cycle pulses.

Top module: `irq_resolver`

## Requirements
- R1: With rotation off, line 0 has the highest priority and line 7 the lowest; of several pending unmasked lines, the lowest-numbered one is presented.
- R2: With rotation on, if line i is lowest then line (i+1) mod 8 is highest. The lowest line resets to 7. It becomes the retired line on a non-specific end-of-interrupt, and the acknowledged line on an automatically retired acknowledge.
- R3: A line whose `mask_in` bit is 1 never raises `irq_out`; clearing the mask bit lets a held request through.
- R4: `irq_out` is high only while some pending unmasked line ranks strictly above every in-service line; otherwise it is low.
- R5: `eoi_valid` with `eoi_specific`=0 clears the highest-ranked set bit of `isr_out` at the clock edge.
- R6: `eoi_valid` with `eoi_specific`=1 clears `isr_out` bit `eoi_level`.
- R7: With `cfg_auto_eoi`=1, an acknowledge sets no `isr_out` bit.
- R8: An acknowledge latches `vec_out` = {`cfg_vec_base`, winning line number}, with the line number in bits 2..0. It holds that value until the next accepted acknowledge.
- R9: With `cfg_level`=0, a request bit sets one edge after a rising input and stays set until acknowledged, even if the input falls. With `cfg_level`=1, the request bit copies the input one edge later.
- R10: An `ack` pulse while `irq_out` is high sets the winner's `isr_out` bit and clears its request bit. An `ack` pulse while `irq_out` is low changes nothing.
- R11: After reset, `irq_out`=0, `vec_out`=0 and `isr_out`=0.
- R12: An acknowledge and an end-of-interrupt command in the same cycle both take effect: the named or top bit is cleared and the winner's bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| req_in | input | 8 | Interrupt request lines |
| mask_in | input | 8 | Per-line block bits, 1 = blocked |
| cfg_level | input | 1 | 1 = level capture, 0 = rising-edge capture |
| cfg_rotate | input | 1 | 1 = rotating priority, 0 = fixed priority |
| cfg_auto_eoi | input | 1 | 1 = retire in-service bit at acknowledge |
| cfg_vec_base | input | 5 | Upper five bits of the vector |
| ack | input | 1 | Single-cycle acknowledge pulse |
| eoi_valid | input | 1 | Single-cycle end-of-interrupt command |
| eoi_specific | input | 1 | 1 = clear bit `eoi_level`, 0 = clear top in-service bit |
| eoi_level | input | 3 | Line named by a specific end-of-interrupt |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector latched at the last acknowledge |
| isr_out | output | 8 | In-service register |

## Verification
The acknowledge and an end-of-interrupt command can land on the same clock edge. In that case one edge must both set the new winner's in-service bit and clear another bit.

The bench provokes this case in two ways:
- It pulses `ack` for a higher request together with a specific end-of-interrupt naming the line already in service. It then checks that `isr_out` holds only the new line and that `vec_out` names it.
- In the vector table, a non-specific end-of-interrupt coincides with a new rising request. This shows that retirement and capture at the same edge leave the new request presented.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  typedef enum logic [1:0] {
    EOI_NONE    = 2'd0,
    EOI_NONSPEC = 2'd1,
    EOI_SPEC    = 2'd2
  } eoi_kind_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_in,
  input  logic [IW-1:0] lowest,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [IW-1:0] rank
);
  logic [IW-1:0] pos;

  // rank 0 is the line just above "lowest"; scan from worst to best so best wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    rank  = '0;
    pos   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      pos = lowest + IW'(k) + IW'(1);
      if (vec_in[pos]) begin
        found = 1'b1;
        idx   = pos;
        rank  = IW'(k);
      end
    end
  end
endmodule

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         level_mode,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irr_q
);
  logic [N-1:0] prev_q;
  logic [N-1:0] irr_d;

  always_comb begin
    if (level_mode) irr_d = req_in;
    else            irr_d = (irr_q & ~clr) | (req_in & ~prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      prev_q <= '0;
    end else begin
      irr_q  <= irr_d;
      prev_q <= req_in;
    end
  end

  // edge mode keeps every captured bit until it is acknowledged
  p_edge_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && clr == '0) |=> ((irr_q & $past(irr_q)) == $past(irr_q)));
endmodule

// File: rtl/irq_service.sv
module irq_service
  import irq_res_pkg::*;
#(
  parameter int N     = 8,
  parameter int IW    = $clog2(N),
  parameter int VEC_W = 8,
  parameter int BW    = VEC_W - IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_take,
  input  logic [IW-1:0]    win_idx,
  input  logic             auto_eoi,
  input  logic             rotate,
  input  logic             eoi_valid,
  input  logic             eoi_specific,
  input  logic [IW-1:0]    eoi_level,
  input  logic             top_found,
  input  logic [IW-1:0]    top_idx,
  input  logic [BW-1:0]    vec_base,
  output logic [N-1:0]     isr_q,
  output logic [IW-1:0]    low_q,
  output logic [VEC_W-1:0] vec_q
);
  eoi_kind_e       kind;
  logic [N-1:0]    eoi_clr;
  logic [N-1:0]    ack_set;
  logic [N-1:0]    isr_d;
  logic [IW-1:0]   low_d;
  logic            low_en;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    if (!eoi_valid)       kind = EOI_NONE;
    else if (eoi_specific) kind = EOI_SPEC;
    else                  kind = EOI_NONSPEC;
  end

  always_comb begin
    eoi_clr = '0;
    low_d   = low_q;
    low_en  = 1'b0;
    case (kind)
      EOI_SPEC: eoi_clr = N'(1) << eoi_level;
      EOI_NONSPEC: begin
        if (top_found) begin
          eoi_clr = N'(1) << top_idx;
          if (rotate) begin
            low_d  = top_idx;
            low_en = 1'b1;
          end
        end
      end
      default: eoi_clr = '0;
    endcase
    // automatic retirement at acknowledge is the newer event and wins
    if (ack_take && auto_eoi && rotate) begin
      low_d  = win_idx;
      low_en = 1'b1;
    end
    ack_set = (ack_take && !auto_eoi) ? (N'(1) << win_idx) : '0;
    isr_d   = (isr_q & ~eoi_clr) | ack_set;
    vec_d   = {vec_base, win_idx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      low_q <= IW'(N - 1);
      vec_q <= '0;
    end else begin
      isr_q <= isr_d;
      if (low_en)   low_q <= low_d;
      if (ack_take) vec_q <= vec_d;
    end
  end

  p_aeoi_no_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && auto_eoi) |=> !isr_q[$past(win_idx)]);

  p_eoi_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !ack_take) |=> ($countones(isr_q) <= $countones($past(isr_q))));

  p_ack_sets_isr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !auto_eoi && !eoi_valid) |=> isr_q[$past(win_idx)]);
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int N_IN   = 8,
  parameter int VEC_W  = 8,
  localparam int IW    = $clog2(N_IN),
  localparam int BW    = VEC_W - IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  req_in,
  input  logic [N_IN-1:0]  mask_in,
  input  logic             cfg_level,
  input  logic             cfg_rotate,
  input  logic             cfg_auto_eoi,
  input  logic [BW-1:0]    cfg_vec_base,
  input  logic             ack,
  input  logic             eoi_valid,
  input  logic             eoi_specific,
  input  logic [IW-1:0]    eoi_level,
  output logic             irq_out,
  output logic [VEC_W-1:0] vec_out,
  output logic [N_IN-1:0]  isr_out
);
  logic [N_IN-1:0] irr_q;
  logic [N_IN-1:0] pend;
  logic [N_IN-1:0] req_clr;
  logic [N_IN-1:0] isr_q;
  logic [IW-1:0]   low_q;
  logic [IW-1:0]   eff_low;
  logic            p_found, s_found;
  logic [IW-1:0]   p_idx, p_rank, s_idx, s_rank;
  logic            qualify;
  logic            ack_take;

  assign eff_low  = cfg_rotate ? low_q : IW'(N_IN - 1);
  assign pend     = irr_q & ~mask_in;
  assign qualify  = p_found && (!s_found || (p_rank < s_rank));
  assign ack_take = ack && qualify;
  assign req_clr  = ack_take ? (N_IN'(1) << p_idx) : '0;

  irq_req_capture #(.N(N_IN)) u_cap (
    .clk(clk), .rst_n(rst_n), .level_mode(cfg_level),
    .req_in(req_in), .clr(req_clr), .irr_q(irr_q)
  );

  irq_prio_pick #(.N(N_IN), .IW(IW)) u_pick_req (
    .vec_in(pend), .lowest(eff_low), .found(p_found), .idx(p_idx), .rank(p_rank)
  );

  irq_prio_pick #(.N(N_IN), .IW(IW)) u_pick_isr (
    .vec_in(isr_q), .lowest(eff_low), .found(s_found), .idx(s_idx), .rank(s_rank)
  );

  irq_service #(.N(N_IN), .IW(IW), .VEC_W(VEC_W), .BW(BW)) u_svc (
    .clk(clk), .rst_n(rst_n), .ack_take(ack_take), .win_idx(p_idx),
    .auto_eoi(cfg_auto_eoi), .rotate(cfg_rotate),
    .eoi_valid(eoi_valid), .eoi_specific(eoi_specific), .eoi_level(eoi_level),
    .top_found(s_found), .top_idx(s_idx), .vec_base(cfg_vec_base),
    .isr_q(isr_q), .low_q(low_q), .vec_q(vec_out)
  );

  assign irq_out = qualify;
  assign isr_out = isr_q;

  p_irq_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((irr_q & ~mask_in) != '0));

  p_ack_clears_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !cfg_level) |=> !irr_q[$past(p_idx)] || $rose(req_in[$past(p_idx)]));
endmodule

// File: tb/irq_resolver_test.sv
module irq_resolver_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] req;
    logic [7:0] mask;
    logic       ack;
    logic       eoi_v;
    logic       eoi_s;
    logic [2:0] lvl;
    logic       exp_irq;
    logic [7:0] exp_vec;
    logic [7:0] exp_isr;
  } step_t;

  // edge mode, fixed priority, base 5'h04 (vectors 0x20..0x27)
  localparam int NSTEP = 13;
  localparam step_t TBL [NSTEP] = '{
    '{8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 8'h00},
    '{8'h28, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 8'h00, 8'h00},
    '{8'h28, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 8'h23, 8'h08},
    '{8'h2A, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 8'h23, 8'h08},
    '{8'h2A, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 8'h21, 8'h0A},
    '{8'h2A, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 8'h21, 8'h08},
    '{8'h2A, 8'h00, 1'b0, 1'b1, 1'b1, 3'd3, 1'b1, 8'h21, 8'h00},
    '{8'h2A, 8'h20, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 8'h21, 8'h00},
    '{8'h2A, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 8'h21, 8'h00},
    '{8'h2A, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 8'h25, 8'h20},
    '{8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 8'h25, 8'h20},
    '{8'h01, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 8'h25, 8'h00},
    '{8'h01, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 8'h20, 8'h01}
  };

  logic       clk;
  logic       rst_n;
  logic [7:0] req_in, mask_in;
  logic       cfg_level, cfg_rotate, cfg_auto_eoi;
  logic [4:0] cfg_vec_base;
  logic       ack, eoi_valid, eoi_specific;
  logic [2:0] eoi_level;
  logic       irq_out;
  logic [7:0] vec_out, isr_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  irq_resolver uut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .mask_in(mask_in),
    .cfg_level(cfg_level), .cfg_rotate(cfg_rotate), .cfg_auto_eoi(cfg_auto_eoi),
    .cfg_vec_base(cfg_vec_base), .ack(ack), .eoi_valid(eoi_valid),
    .eoi_specific(eoi_specific), .eoi_level(eoi_level),
    .irq_out(irq_out), .vec_out(vec_out), .isr_out(isr_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] rq, input logic [7:0] mk, input logic a,
                       input logic ev, input logic es, input logic [2:0] lv);
    req_in = rq; mask_in = mk; ack = a;
    eoi_valid = ev; eoi_specific = es; eoi_level = lv;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_in = '0; mask_in = '0; ack = 1'b0;
    eoi_valid = 1'b0; eoi_specific = 1'b0; eoi_level = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cfg_level = 1'b0; cfg_rotate = 1'b0; cfg_auto_eoi = 1'b0; cfg_vec_base = 5'h04;
    do_reset();
    // R11 reset state
    chk("R11 irq after reset", {7'd0, irq_out}, 8'h00);
    chk("R11 vec after reset", vec_out, 8'h00);
    chk("R11 isr after reset", isr_out, 8'h00);

    // table walk: R1/R3/R4/R5/R6/R8/R9/R10/R12
    for (int i = 0; i < NSTEP; i++) begin
      apply(TBL[i].req, TBL[i].mask, TBL[i].ack, TBL[i].eoi_v, TBL[i].eoi_s, TBL[i].lvl);
      chk($sformatf("R1/R3/R4/R5/R6/R8/R10 step %0d irq", i), {7'd0, irq_out}, {7'd0, TBL[i].exp_irq});
      chk($sformatf("R1/R8/R10 step %0d vec", i), vec_out, TBL[i].exp_vec);
      chk($sformatf("R5/R6/R10/R12 step %0d isr", i), isr_out, TBL[i].exp_isr);
    end

    // R3 mask holds off a captured request, unmask releases it
    do_reset();
    apply(8'h01, 8'hFF, 0, 0, 0, 3'd0);
    chk("R3 masked irq", {7'd0, irq_out}, 8'h00);
    apply(8'h01, 8'hFE, 0, 0, 0, 3'd0);
    chk("R3 unmasked irq", {7'd0, irq_out}, 8'h01);

    // R9 level mode follows the line
    cfg_level = 1'b1;
    do_reset();
    apply(8'h10, 8'h00, 0, 0, 0, 3'd0);
    chk("R9 level high", {7'd0, irq_out}, 8'h01);
    apply(8'h00, 8'h00, 0, 0, 0, 3'd0);
    chk("R9 level drop", {7'd0, irq_out}, 8'h00);

    // R9 edge mode holds a short pulse
    cfg_level = 1'b0;
    do_reset();
    apply(8'h10, 8'h00, 0, 0, 0, 3'd0);
    apply(8'h00, 8'h00, 0, 0, 0, 3'd0);
    chk("R9 edge held", {7'd0, irq_out}, 8'h01);
    apply(8'h00, 8'h00, 1, 0, 0, 3'd0);
    chk("R8 vec of held edge", vec_out, 8'h24);

    // R2 + R7: rotation with automatic retirement
    cfg_rotate = 1'b1; cfg_auto_eoi = 1'b1;
    do_reset();
    apply(8'h04, 8'h00, 0, 0, 0, 3'd0);
    apply(8'h04, 8'h00, 1, 0, 0, 3'd0);
    chk("R8 aeoi vec", vec_out, 8'h22);
    chk("R7 aeoi isr empty", isr_out, 8'h00);
    apply(8'h0E, 8'h00, 0, 0, 0, 3'd0);
    apply(8'h0E, 8'h00, 1, 0, 0, 3'd0);
    chk("R2 line 3 above line 1 after rotate", vec_out, 8'h23);
    chk("R7 isr still empty", isr_out, 8'h00);

    // R2 + R5: rotation by non-specific retirement
    cfg_auto_eoi = 1'b0;
    do_reset();
    apply(8'h01, 8'h00, 0, 0, 0, 3'd0);
    apply(8'h01, 8'h00, 1, 0, 0, 3'd0);
    chk("R10 isr bit0 set", isr_out, 8'h01);
    apply(8'h00, 8'h00, 0, 1, 0, 3'd0);
    chk("R5 nonspecific clear", isr_out, 8'h00);
    apply(8'h81, 8'h00, 0, 0, 0, 3'd0);
    apply(8'h81, 8'h00, 1, 0, 0, 3'd0);
    chk("R2 line 7 above line 0 after rotate", vec_out, 8'h27);

    // R12 + R4: acknowledge and specific retirement on one edge
    cfg_rotate = 1'b0;
    do_reset();
    apply(8'h10, 8'h00, 0, 0, 0, 3'd0);
    apply(8'h10, 8'h00, 1, 0, 0, 3'd0);
    chk("R10 isr bit4", isr_out, 8'h10);
    apply(8'h14, 8'h00, 0, 0, 0, 3'd0);
    chk("R4 higher line preempts", {7'd0, irq_out}, 8'h01);
    apply(8'h14, 8'h00, 1, 1, 1, 3'd4);
    chk("R12 isr after ack+eoi", isr_out, 8'h04);
    chk("R12 vec after ack+eoi", vec_out, 8'h22);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule